// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block interprets the write cycles that a host issues to a parallel NOR-style flash and owns a small byte-addressed storage array behind them. Each bus write carries a byte offset, a data word and an access size. In the first cycle of a sequence the low data byte is a command code. Later cycles carry program data, a confirm code, or a word count, depending on the latched command and the cycle number.

Reads return one of four things, chosen by the latched command: array contents, the 8-bit status register, an identifier byte, or a query-table byte. A `read_only` input turns every program and erase attempt into a sticky error flag in the status register, and the array is left unchanged. The storage comes out of reset filled with 0xFF.

Read data is registered. `rd_valid` rises on the cycle after `rd_en`, and the data reflects the state before any write issued in that same cycle. Access size codes are 0 for one byte, 1 for two bytes and 2 or 3 for four bytes. Multi-byte data uses little-endian lanes: data byte k maps to offset+k, and the offset wraps within the array.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, array reads return 0xFF in every byte and the status register holds 0x80. `seq_err` is low, and `rd_valid` follows `rd_en` by exactly one cycle.
- R2: In cycle 0, the codes 0x00, 0xF0 and 0xFF select array reads. Any code not listed in R3 to R10 also selects array reads and pulses `seq_err` high for one cycle, on the cycle after the write.
- R3: Code 0x10 or 0x40 arms a program. The next write stores its data at its own offset for its access size and sets status bit 7 (0x80). Reads then return status until a new command is issued.
- R4: Code 0x20 fills the whole sector containing the offset with 0xFF and sets 0x80. Its second write must be 0xD0, which keeps status reads, or 0xFF, which selects array reads. Any other value selects array reads and pulses `seq_err`.
- R5: While `read_only` is high, a program leaves the array unchanged and sets status bit 4 (0x10), and an erase leaves the array unchanged and sets status bit 5 (0x20).
- R6: Status bits only accumulate. Code 0x50 clears the status to 0x00 and selects array reads.
- R7: Code 0x70 selects status reads. Code 0x90 selects identifier reads, where the index is offset divided by the bus width in bytes: index 0 gives MANUF_ID, index 1 gives DEVICE_ID, and any other index gives 0x00, copied into every byte of the access. Neither code starts a second cycle.
- R8: Code 0x98 selects query reads, with the index formed as in R7. Index 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59; index 0x13 and 0x2C give 0x01; index 0x27 gives log2 of the array size; every other index gives 0x00. Only a following write of 0xFF leaves query mode.
- R9: Code 0x60 takes a second write. 0xD0 or 0x01 sets 0x80 and keeps status reads. Any other value selects array reads without `seq_err`.
- R10: Code 0xE8 sets 0x80. The next write gives a count N, taken from the low 8*DEV_BYTES data bits. The following N+1 writes each store their data at their own offsets.
- R11: After the last buffered data write, a write of 0xD0 keeps status reads. Any other value selects array reads, and the data already stored stays in the array.
- R12: In status reads, byte lane k of the access carries the status when k is a multiple of DEV_BYTES and is 0x00 otherwise. Bytes above the access size are 0x00 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | $clog2(ARRAY_BYTES) | Byte offset of the access |
| size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| wdata | input | 8*BUS_BYTES | Write data; low byte is the command code |
| read_only | input | 1 | Turns program and erase into error flags |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8*BUS_BYTES | Read data |
| seq_err | output | 1 | One-cycle pulse on an unsupported command sequence |

## Verification
The in-line properties watch several rules on every clock:
- status bits never fall except on a clear command;
- a program data write always leaves the ready bit set;
- a read-only program always raises the program-error bit;
- query mode survives every write other than 0xFF;
- the buffered-write count steps down by one per data write, and cycles 2 and 3 occur only under the buffered command;
- a single-byte status read carries the status with zero upper bytes;
- a `seq_err` pulse always coincides with array mode.

Three behaviours depend on the sequence of operations, so only the bench scenarios can show them:
- the exact contents left by programs, buffered writes and aborted buffers;
- the full extent of a sector erase and the sectors it leaves untouched;
- the identifier and query bytes at chosen offsets.

// File: rtl/nce_pkg.sv
package nce_pkg;

  typedef enum logic [2:0] {
    M_ARRAY, M_PROG, M_ERASE, M_LOCK, M_STAT, M_IDENT, M_QUERY, M_BUF
  } mode_e;

  localparam logic [7:0] OP_ARR_A    = 8'h00;
  localparam logic [7:0] OP_ARR_B    = 8'hF0;
  localparam logic [7:0] OP_ARR_C    = 8'hFF;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFFER   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_UNLOCK   = 8'h01;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  // access size code to byte count
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/nce_store.sv
module nce_store #(
  parameter int ARRAY_BYTES  = 256,
  parameter int SECTOR_BYTES = 32,
  parameter int BUS_BYTES    = 4,
  localparam int AW = $clog2(ARRAY_BYTES),
  localparam int SW = $clog2(SECTOR_BYTES),
  localparam int DW = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [BUS_BYTES-1:0] wr_lanes,
  input  logic                 erase_en,
  input  logic [AW-1:0]        erase_addr,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_bytes
);

  logic [7:0]             mem_q [ARRAY_BYTES];
  logic [7:0]             mem_d [ARRAY_BYTES];
  logic [ARRAY_BYTES-1:0] mem_en;

  // next-state: sector fill or lane write per byte
  always_comb begin
    for (int i = 0; i < ARRAY_BYTES; i++) begin
      mem_en[i] = 1'b0;
      mem_d[i]  = mem_q[i];
      if (erase_en && ((erase_addr >> SW) == (AW'(i) >> SW))) begin
        mem_en[i] = 1'b1;
        mem_d[i]  = 8'hFF;
      end
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (wr_en && wr_lanes[k] && ((wr_addr + AW'(k)) == AW'(i))) begin
          mem_en[i] = 1'b1;
          mem_d[i]  = wr_data[8*k +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < ARRAY_BYTES; i++) begin
        if (mem_en[i]) mem_q[i] <= mem_d[i];
      end
    end
  end

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_rd
    logic [AW-1:0] a;
    assign a = rd_addr + AW'(k);
    assign rd_bytes[8*k +: 8] = mem_q[a];
  end

  // R4: the base byte of an erased sector reads 0xFF afterwards
  a_r4_sector_base: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (mem_q[{$past(erase_addr[AW-1:SW]), SW'(0)}] == 8'hFF));

  // R3: lane 0 of a store lands at its own offset
  a_r3_lane0_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lanes[0] && !erase_en) |=> (mem_q[$past(wr_addr)] == $past(wr_data[7:0])));

endmodule

// File: rtl/nce_seq.sv
module nce_seq
  import nce_pkg::*;
#(
  parameter int DEV_BYTES = 1,
  localparam int CW = 8 * DEV_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    op,
  input  logic [CW-1:0] cnt_in,
  input  logic          read_only,
  output mode_e         mode,
  output logic [7:0]    status,
  output logic          store_we,
  output logic          erase_en,
  output logic          seq_err
);

  mode_e         mode_q, mode_d;
  logic [1:0]    cyc_q, cyc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    status_q, status_d;
  logic          err_q, err_d;

  always_comb begin
    mode_d   = mode_q;
    cyc_d    = cyc_q;
    cnt_d    = cnt_q;
    status_d = status_q;
    err_d    = 1'b0;
    store_we = 1'b0;
    erase_en = 1'b0;
    if (wr_en) begin
      case (cyc_q)
        2'd0: begin
          case (op)
            OP_ARR_A, OP_ARR_B, OP_ARR_C: mode_d = M_ARRAY;
            OP_PROG_A, OP_PROG_B: begin
              mode_d = M_PROG;
              cyc_d  = 2'd1;
            end
            OP_ERASE: begin
              if (read_only) status_d = status_d | ST_ERASE_ERR;
              else           erase_en = 1'b1;
              status_d = status_d | ST_READY;
              mode_d   = M_ERASE;
              cyc_d    = 2'd1;
            end
            OP_CLEAR: begin
              status_d = 8'h00;
              mode_d   = M_ARRAY;
            end
            OP_LOCK: begin
              mode_d = M_LOCK;
              cyc_d  = 2'd1;
            end
            OP_STATUS: mode_d = M_STAT;
            OP_IDENT:  mode_d = M_IDENT;
            OP_QUERY: begin
              mode_d = M_QUERY;
              cyc_d  = 2'd1;
            end
            OP_BUFFER: begin
              status_d = status_d | ST_READY;
              mode_d   = M_BUF;
              cyc_d    = 2'd1;
            end
            default: begin
              err_d  = 1'b1;
              mode_d = M_ARRAY;
            end
          endcase
        end
        2'd1: begin
          case (mode_q)
            M_PROG: begin
              if (read_only) status_d = status_d | ST_PROG_ERR;
              else           store_we = 1'b1;
              status_d = status_d | ST_READY;
              cyc_d    = 2'd0;
            end
            M_ERASE: begin
              cyc_d = 2'd0;
              if (op == OP_CONFIRM) begin
                status_d = status_d | ST_READY;
              end else begin
                mode_d = M_ARRAY;
                err_d  = (op != OP_ARR_C);
              end
            end
            M_LOCK: begin
              cyc_d = 2'd0;
              if (op == OP_CONFIRM || op == OP_UNLOCK) status_d = status_d | ST_READY;
              else                                      mode_d   = M_ARRAY;
            end
            M_QUERY: begin
              if (op == OP_ARR_C) begin
                mode_d = M_ARRAY;
                cyc_d  = 2'd0;
              end
            end
            M_BUF: begin
              cnt_d = cnt_in;
              cyc_d = 2'd2;
            end
            default: begin
              err_d  = 1'b1;
              mode_d = M_ARRAY;
              cyc_d  = 2'd0;
            end
          endcase
        end
        2'd2: begin
          if (read_only) status_d = status_d | ST_PROG_ERR;
          else           store_we = 1'b1;
          status_d = status_d | ST_READY;
          if (cnt_q == '0) cyc_d = 2'd3;
          cnt_d = cnt_q - CW'(1);
        end
        default: begin
          cyc_d = 2'd0;
          if (op == OP_CONFIRM) status_d = status_d | ST_READY;
          else                  mode_d   = M_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_ARRAY;
      cyc_q    <= 2'd0;
      cnt_q    <= '0;
      status_q <= ST_READY;
      err_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      cyc_q    <= cyc_d;
      cnt_q    <= cnt_d;
      status_q <= status_d;
      err_q    <= err_d;
    end
  end

  assign mode    = mode_q;
  assign status  = status_q;
  assign seq_err = err_q;

  a_r3_prog_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == 2'd1 && mode_q == M_PROG) |=> (status_q[7] && cyc_q == 2'd0));

  a_r5_ro_prog_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && read_only && cyc_q == 2'd1 && mode_q == M_PROG) |=> status_q[4]);

  a_r6_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cyc_q == 2'd0 && op == OP_CLEAR) |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r8_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_q == M_QUERY && cyc_q == 2'd1 && op != OP_ARR_C) |=> (mode_q == M_QUERY));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == 2'd2 && cnt_q != '0) |=> (cyc_q == 2'd2 && cnt_q == $past(cnt_q) - CW'(1)));

  a_r10_buf_only: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q[1] |-> (mode_q == M_BUF));

  a_r2_err_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (mode_q == M_ARRAY && cyc_q == 2'd0));

endmodule

// File: rtl/nce_rdout.sv
module nce_rdout
  import nce_pkg::*;
#(
  parameter int         ARRAY_BYTES = 256,
  parameter int         BUS_BYTES   = 4,
  parameter int         DEV_BYTES   = 1,
  parameter logic [7:0] MANUF_ID    = 8'h89,
  parameter logic [7:0] DEVICE_ID   = 8'h18,
  localparam int AW = $clog2(ARRAY_BYTES),
  localparam int DW = 8 * BUS_BYTES,
  localparam int BW = $clog2(BUS_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  mode_e         mode,
  input  logic [7:0]    status,
  input  logic [DW-1:0] arr_bytes,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  localparam logic [7:0] SIZE_CODE = 8'($clog2(ARRAY_BYTES));

  logic [AW-1:0] idx;
  logic [7:0]    id_byte, qry_byte;
  logic [3:0]    nb;
  logic [DW-1:0] data_d;
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign idx = addr >> BW;
  assign nb  = size_bytes(size);

  always_comb begin
    case (int'(idx))
      0:       id_byte = MANUF_ID;
      1:       id_byte = DEVICE_ID;
      default: id_byte = 8'h00;
    endcase
    case (int'(idx))
      'h10:       qry_byte = 8'h51;
      'h11:       qry_byte = 8'h52;
      'h12:       qry_byte = 8'h59;
      'h13, 'h2C: qry_byte = 8'h01;
      'h27:       qry_byte = SIZE_CODE;
      default:    qry_byte = 8'h00;
    endcase
  end

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    localparam bit HEAD = ((k % DEV_BYTES) == 0);
    logic [7:0] lane;
    always_comb begin
      case (mode)
        M_ARRAY: lane = arr_bytes[8*k +: 8];
        M_IDENT: lane = id_byte;
        M_QUERY: lane = qry_byte;
        default: lane = HEAD ? status : 8'h00;
      endcase
    end
    assign data_d[8*k +: 8] = (k < int'(nb)) ? lane : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) data_q <= data_d;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  a_r12_byte_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == M_STAT && size == 2'd0) |=>
      (rd_data[DW-1:8] == '0 && rd_data[7:0] == $past(status)));

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nce_pkg::*;
#(
  parameter int         ARRAY_BYTES  = 256,
  parameter int         SECTOR_BYTES = 32,
  parameter int         BUS_BYTES    = 4,
  parameter int         DEV_BYTES    = 1,
  parameter logic [7:0] MANUF_ID     = 8'h89,
  parameter logic [7:0] DEVICE_ID    = 8'h18,
  localparam int AW = $clog2(ARRAY_BYTES),
  localparam int DW = 8 * BUS_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic          read_only,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          seq_err
);

  localparam int CW = 8 * DEV_BYTES;

  mode_e                mode;
  logic [7:0]           status;
  logic                 store_we, erase_en;
  logic [BUS_BYTES-1:0] lanes;
  logic [DW-1:0]        arr_bytes;

  always_comb begin
    for (int k = 0; k < BUS_BYTES; k++) lanes[k] = (k < int'(size_bytes(size)));
  end

  nce_seq #(.DEV_BYTES(DEV_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(wdata[7:0]),
    .cnt_in(wdata[CW-1:0]), .read_only(read_only), .mode(mode),
    .status(status), .store_we(store_we), .erase_en(erase_en), .seq_err(seq_err)
  );

  nce_store #(
    .ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .BUS_BYTES(BUS_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_we), .wr_addr(addr), .wr_data(wdata),
    .wr_lanes(lanes), .erase_en(erase_en), .erase_addr(addr), .rd_addr(addr),
    .rd_bytes(arr_bytes)
  );

  nce_rdout #(
    .ARRAY_BYTES(ARRAY_BYTES), .BUS_BYTES(BUS_BYTES), .DEV_BYTES(DEV_BYTES),
    .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID)
  ) u_rdout (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .size(size),
    .mode(mode), .status(status), .arr_bytes(arr_bytes),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: tb/sim_nor_cmd_engine.sv
module sim_nor_cmd_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en, read_only;
  logic [7:0]  addr;
  logic [1:0]  size;
  logic [31:0] wdata;
  logic        rd_valid, seq_err;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] e_cur;
  string       t_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .read_only(read_only), .rd_valid(rd_valid),
    .rd_data(rd_data), .seq_err(seq_err)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected read data actual %h expected none", rd_data);
      end else begin
        e_cur = exp_q.pop_front();
        t_cur = tag_q.pop_front();
        if (rd_data !== e_cur) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t_cur, rd_data, e_cur);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
    addr = a; wdata = d; size = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; size = s; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_err(input logic e, input string t);
    checks++;
    if (seq_err !== e) begin
      errors++;
      $display("FAIL %s seq_err actual %b expected %b", t, seq_err, e);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; read_only = 1'b0;
    addr = '0; size = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin errors++; $display("FAIL R1 rd_valid actual %b expected 0", rd_valid); end
    chk_err(1'b0, "R1 reset");
    rd(8'h00, 2'd2, 32'hFFFF_FFFF, "R1 preload");
    rd(8'hFC, 2'd2, 32'hFFFF_FFFF, "R1 preload top");
    // status mode
    wr(8'h00, 32'h70, 2'd0);
    rd(8'h00, 2'd2, 32'h8080_8080, "R1 R12 reset status x4");
    rd(8'h00, 2'd0, 32'h0000_0080, "R12 status x1");
    rd(8'h00, 2'd1, 32'h0000_8080, "R12 status x2");
    // programs
    wr(8'h00, 32'hFF, 2'd0);
    wr(8'h08, 32'h40, 2'd0);
    wr(8'h08, 32'h1234_5678, 2'd2);
    rd(8'h00, 2'd0, 32'h0000_0080, "R3 status after program");
    wr(8'h00, 32'hFF, 2'd0);
    rd(8'h08, 2'd2, 32'h1234_5678, "R3 word stored");
    rd(8'h09, 2'd1, 32'h0000_3456, "R3 lanes");
    wr(8'h00, 32'h10, 2'd0);
    wr(8'h20, 32'hAABB_CCDD, 2'd1);
    wr(8'h00, 32'hF0, 2'd0);
    chk_err(1'b0, "R2 F0 accepted");
    rd(8'h20, 2'd2, 32'hFFFF_CCDD, "R3 half store");
    wr(8'h00, 32'h40, 2'd0);
    wr(8'h3F, 32'h5A, 2'd0);
    wr(8'h00, 32'h00, 2'd0);
    chk_err(1'b0, "R2 00 accepted");
    rd(8'h3C, 2'd2, 32'h5AFF_FFFF, "R3 byte store");
    // erase sector 0x20..0x3F
    wr(8'h25, 32'h20, 2'd0);
    wr(8'h00, 32'hD0, 2'd0);
    chk_err(1'b0, "R4 confirm");
    rd(8'h00, 2'd0, 32'h0000_0080, "R4 status after confirm");
    wr(8'h00, 32'hFF, 2'd0);
    rd(8'h20, 2'd2, 32'hFFFF_FFFF, "R4 sector start");
    rd(8'h3C, 2'd2, 32'hFFFF_FFFF, "R4 sector end");
    rd(8'h08, 2'd2, 32'h1234_5678, "R4 other sector");
    wr(8'h40, 32'h20, 2'd0);
    wr(8'h00, 32'h33, 2'd0);
    chk_err(1'b1, "R4 bad confirm");
    rd(8'h08, 2'd2, 32'h1234_5678, "R4 array after bad confirm");
    wr(8'h40, 32'h20, 2'd0);
    wr(8'h00, 32'hFF, 2'd0);
    chk_err(1'b0, "R4 abort");
    rd(8'h08, 2'd2, 32'h1234_5678, "R4 array after abort");
    // unknown command
    wr(8'h00, 32'h77, 2'd0);
    chk_err(1'b1, "R2 unknown");
    @(negedge clk);
    chk_err(1'b0, "R2 single pulse");
    rd(8'h08, 2'd2, 32'h1234_5678, "R2 array after unknown");
    // read-only
    read_only = 1'b1;
    wr(8'h08, 32'h40, 2'd0);
    wr(8'h08, 32'h0000_0000, 2'd2);
    rd(8'h00, 2'd0, 32'h0000_0090, "R5 program error flag");
    wr(8'h08, 32'h20, 2'd0);
    wr(8'h00, 32'hD0, 2'd0);
    rd(8'h00, 2'd0, 32'h0000_00B0, "R5 R6 erase error flag");
    read_only = 1'b0;
    wr(8'h00, 32'hFF, 2'd0);
    rd(8'h08, 2'd2, 32'h1234_5678, "R5 array unchanged");
    wr(8'h00, 32'h40, 2'd0);
    wr(8'h50, 32'h11, 2'd0);
    rd(8'h00, 2'd0, 32'h0000_00B0, "R6 bits accumulate");
    wr(8'h00, 32'h50, 2'd0);
    rd(8'h50, 2'd0, 32'h0000_0011, "R6 clear returns to array");
    wr(8'h00, 32'h70, 2'd0);
    rd(8'h00, 2'd0, 32'h0000_0000, "R6 cleared status");
    // identifier
    wr(8'h00, 32'h90, 2'd0);
    chk_err(1'b0, "R7 ident accepted");
    rd(8'h00, 2'd2, 32'h8989_8989, "R7 manufacturer");
    rd(8'h04, 2'd1, 32'h0000_1818, "R7 device");
    rd(8'h08, 2'd0, 32'h0000_0000, "R7 other index");
    // query
    wr(8'h00, 32'h98, 2'd0);
    rd(8'h40, 2'd0, 32'h0000_0051, "R8 Q");
    rd(8'h44, 2'd0, 32'h0000_0052, "R8 R");
    rd(8'h48, 2'd0, 32'h0000_0059, "R8 Y");
    rd(8'h9C, 2'd0, 32'h0000_0008, "R8 size code");
    wr(8'h00, 32'h70, 2'd0);
    rd(8'h40, 2'd2, 32'h5151_5151, "R8 stays in query");
    wr(8'h00, 32'hFF, 2'd0);
    rd(8'h08, 2'd2, 32'h1234_5678, "R8 leaves on FF");
    // lock
    wr(8'h00, 32'h60, 2'd0);
    wr(8'h00, 32'h01, 2'd0);
    chk_err(1'b0, "R9 unlock");
    rd(8'h00, 2'd0, 32'h0000_0080, "R9 ready after unlock");
    wr(8'h00, 32'h60, 2'd0);
    wr(8'h00, 32'h22, 2'd0);
    chk_err(1'b0, "R9 other value no error");
    rd(8'h08, 2'd2, 32'h1234_5678, "R9 array after other value");
    // buffered write: count 0x102 masked to 2 -> three data writes
    wr(8'h00, 32'hE8, 2'd0);
    wr(8'h00, 32'h0000_0102, 2'd2);
    wr(8'h60, 32'h1111_1111, 2'd2);
    wr(8'h64, 32'h2222_2222, 2'd2);
    wr(8'h68, 32'h3333_3333, 2'd2);
    wr(8'h00, 32'hD0, 2'd0);
    chk_err(1'b0, "R11 confirm");
    rd(8'h00, 2'd0, 32'h0000_0080, "R11 status after confirm");
    wr(8'h00, 32'hFF, 2'd0);
    rd(8'h60, 2'd2, 32'h1111_1111, "R10 first word");
    rd(8'h64, 2'd2, 32'h2222_2222, "R10 second word");
    rd(8'h68, 2'd2, 32'h3333_3333, "R10 last word");
    rd(8'h6C, 2'd2, 32'hFFFF_FFFF, "R10 no extra word");
    rd(8'h00, 2'd2, 32'hFFFF_FFFF, "R10 confirm not stored");
    // buffered write aborted at confirm
    wr(8'h00, 32'hE8, 2'd0);
    wr(8'h00, 32'h0000_0000, 2'd2);
    wr(8'h70, 32'hCAFE_F00D, 2'd2);
    wr(8'h00, 32'h55, 2'd0);
    rd(8'h70, 2'd2, 32'hCAFE_F00D, "R11 abort keeps data");
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule